// File: doc/BRIEF.md
# Serial EEPROM Word Pointer and Page Write Buffer

This block sits behind the byte-level engine of a two-wire serial EEPROM slave. It keeps the word-address pointer and collects write data in a 16-byte page buffer. It also owns a register-based store that holds a 512-byte main array and a 16-byte configuration area. The front end sends it one-cycle event pulses: an address byte, a data byte, a read-byte request and a stop. The block answers with read data and the updated pointer.

Each access runs in one of three address spaces, selected on `space_i`:
- a single 256-byte bank, with pointer bit 8 naming the bank;
- the combined 512-byte space;
- the 16-byte configuration area.

`space_i` must stay steady for the whole of a transaction.

Write data goes into the buffer at the pointer's in-page offset. Only the low four pointer bits advance, so a long write wraps inside its page. A stop commits only the buffer slots that received data. Reads return the byte at the pointer and advance it, wrapping at the end of the selected space. A random read is an address event followed directly by read events.

Top module: `ee_word_ctl`

## Requirements
- R1: An address event loads the pointer. In the bank space (`space_i`=0) and the combined space (`space_i`=1) the pointer becomes {`addr_hi_i`, `byte_i`}. In the configuration space (`space_i`=2) it becomes `byte_i[3:0]` with the upper bits zero, and `addr_hi_i` is ignored.
- R2: A data event stores `byte_i` in the buffer slot given by pointer bits [3:0]. It then increments pointer bits [3:0] modulo 16 and leaves bits [8:4] unchanged, so a write at offset Fh leaves offset 0h of the same page.
- R3: A stop that follows at least one data event commits every written slot to the page given by pointer bits [8:4], and `commit_o` pulses on the next cycle. Slots not written keep their old contents. A stop with no data byte commits nothing.
- R4: When one slot is written more than once before a stop, the last byte written is the one committed.
- R5: A read event sets `rd_data_o` to the stored byte at the pointer, with `rd_valid_o` high, on the next cycle. It then advances the pointer.
- R6: In the bank space a read at offset FFh wraps bits [7:0] to 00h and keeps bit 8.
- R7: In the combined space reads run across both banks: 0FFh is followed by 100h, and 1FFh by 000h.
- R8: The configuration area is separate from the main array. Reads there wrap from Fh to 0h.
- R9: Configuration address Fh always reads the revision code (default 3Ch), and writes to it have no effect.
- R10: An address event followed directly by read events (random read) returns data from the loaded address. The stop that ends it commits nothing.
- R11: After reset the pointer is 0, `rd_valid_o` and `commit_o` are low, and all stored bytes other than the revision code read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| space_i | input | 2 | Address space: 0 bank, 1 combined, 2 configuration |
| addr_ev_i | input | 1 | Word address byte received |
| addr_hi_i | input | 1 | Address bit 8 loaded with the address byte |
| data_ev_i | input | 1 | Write data byte received |
| rd_ev_i | input | 1 | Read byte requested |
| stop_ev_i | input | 1 | Stop condition received |
| byte_i | input | 8 | Address or data byte for the event |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle |
| ptr_o | output | 9 | Word-address pointer |
| commit_o | output | 1 | Page committed, one cycle |

## Verification
Every result is due exactly one clock edge after its event:
- `ptr_o` after an address, data or read event;
- `rd_data_o` and `rd_valid_o` after a read event;
- `commit_o` after a stop, together with the store update.

Stored bytes are first visible to a read event issued in the following cycle. The bench drives each event on a falling edge, holds it for one cycle and samples on the next falling edge. Sampling there places every check after the one register stage that the result passes through.

// File: rtl/ee_word_pkg.sv
package ee_word_pkg;
  typedef enum logic [1:0] {
    SP_BANK = 2'd0,
    SP_COMB = 2'd1,
    SP_CFG  = 2'd2
  } space_e;
endpackage

// File: rtl/ee_ptr.sv
module ee_ptr
  import ee_word_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned BANK_AW = 8,
  parameter int unsigned PAGE_AW = 4,
  parameter int unsigned CFG_AW  = 4,
  localparam int unsigned AW     = BANK_AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    space_i,
  input  logic          addr_ev_i,
  input  logic          addr_hi_i,
  input  logic          data_ev_i,
  input  logic          rd_ev_i,
  input  logic [DW-1:0] byte_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ld_val, pg_next, rd_next;

  always_comb begin
    if (space_i == SP_CFG) ld_val = AW'(byte_i[CFG_AW-1:0]);
    else                   ld_val = {addr_hi_i, byte_i[BANK_AW-1:0]};
    pg_next = {ptr_q[AW-1:PAGE_AW], ptr_q[PAGE_AW-1:0] + PAGE_AW'(1)};
    case (space_i)
      SP_COMB: rd_next = ptr_q + AW'(1);
      SP_CFG:  rd_next = {ptr_q[AW-1:CFG_AW], ptr_q[CFG_AW-1:0] + CFG_AW'(1)};
      default: rd_next = {ptr_q[AW-1], ptr_q[BANK_AW-1:0] + BANK_AW'(1)};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (addr_ev_i) ptr_q <= ld_val;
    else if (data_ev_i) ptr_q <= pg_next;
    else if (rd_ev_i)   ptr_q <= rd_next;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PAGE_AW = 4,
  localparam int unsigned PAGE_N = 1 << PAGE_AW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [PAGE_AW-1:0]            slot_i,
  input  logic [DW-1:0]                 data_i,
  output logic [PAGE_N-1:0][DW-1:0]     buf_o,
  output logic [PAGE_N-1:0]             mask_o
);
  for (genvar s = 0; s < PAGE_N; s++) begin : g_slot
    logic [DW-1:0] d_q;
    logic          v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clr_i) begin
        v_q <= 1'b0;
      end else if (wr_i && slot_i == PAGE_AW'(s)) begin
        d_q <= data_i;
        v_q <= 1'b1;
      end
    end
    assign buf_o[s]  = d_q;
    assign mask_o[s] = v_q;
  end
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int unsigned    DW       = 8,
  parameter int unsigned    BANK_AW  = 8,
  parameter int unsigned    PAGE_AW  = 4,
  parameter int unsigned    CFG_AW   = 4,
  parameter logic [DW-1:0]  REV_CODE = 8'h3C,
  localparam int unsigned   AW       = BANK_AW + 1,
  localparam int unsigned   MEM_N    = 1 << AW,
  localparam int unsigned   PAGE_N   = 1 << PAGE_AW,
  localparam int unsigned   CFG_N    = 1 << CFG_AW,
  localparam int unsigned   PW       = AW - PAGE_AW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic                      cfg_i,
  input  logic [PW-1:0]             page_i,
  input  logic [PAGE_N-1:0]         mask_i,
  input  logic [PAGE_N-1:0][DW-1:0] buf_i,
  input  logic [AW-1:0]             raddr_i,
  output logic [DW-1:0]             rdata_o
);
  logic [MEM_N-1:0][DW-1:0] mem_w;
  logic [CFG_N-1:0][DW-1:0] cfg_w;

  for (genvar i = 0; i < MEM_N; i++) begin : g_mem
    localparam int unsigned SLOT = i % PAGE_N;
    localparam int unsigned PG   = i / PAGE_N;
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (commit_i && !cfg_i && page_i == PW'(PG) && mask_i[SLOT]) q <= buf_i[SLOT];
    end
    assign mem_w[i] = q;
  end

  for (genvar j = 0; j < CFG_N; j++) begin : g_cfg
    if (j == CFG_N - 1) begin : g_rev
      assign cfg_w[j] = REV_CODE;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (commit_i && cfg_i && mask_i[j]) q <= buf_i[j];
      end
      assign cfg_w[j] = q;
    end
  end

  assign rdata_o = cfg_i ? cfg_w[raddr_i[CFG_AW-1:0]] : mem_w[raddr_i];
endmodule

// File: rtl/ee_word_ctl.sv
module ee_word_ctl
  import ee_word_pkg::*;
#(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   BANK_AW  = 8,
  parameter int unsigned   PAGE_AW  = 4,
  parameter int unsigned   CFG_AW   = 4,
  parameter logic [DW-1:0] REV_CODE = 8'h3C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         space_i,
  input  logic               addr_ev_i,
  input  logic               addr_hi_i,
  input  logic               data_ev_i,
  input  logic               rd_ev_i,
  input  logic               stop_ev_i,
  input  logic [DW-1:0]      byte_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               rd_valid_o,
  output logic [BANK_AW:0]   ptr_o,
  output logic               commit_o
);
  localparam int unsigned AW     = BANK_AW + 1;
  localparam int unsigned PAGE_N = 1 << PAGE_AW;

  logic [AW-1:0]             ptr;
  logic [PAGE_N-1:0][DW-1:0] pbuf;
  logic [PAGE_N-1:0]         pmask;
  logic [DW-1:0]             rdata;
  logic                      commit, is_cfg;
  logic [DW-1:0]             rd_data_q;
  logic                      rd_valid_q, commit_q;

  assign is_cfg = (space_i == SP_CFG);
  assign commit = stop_ev_i && (|pmask);

  ee_ptr #(.DW(DW), .BANK_AW(BANK_AW), .PAGE_AW(PAGE_AW), .CFG_AW(CFG_AW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .space_i   (space_i),
    .addr_ev_i (addr_ev_i),
    .addr_hi_i (addr_hi_i),
    .data_ev_i (data_ev_i),
    .rd_ev_i   (rd_ev_i),
    .byte_i    (byte_i),
    .ptr_o     (ptr)
  );

  ee_page_buf #(.DW(DW), .PAGE_AW(PAGE_AW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_ev_i || stop_ev_i),
    .wr_i   (data_ev_i && !addr_ev_i),
    .slot_i (ptr[PAGE_AW-1:0]),
    .data_i (byte_i),
    .buf_o  (pbuf),
    .mask_o (pmask)
  );

  ee_store #(.DW(DW), .BANK_AW(BANK_AW), .PAGE_AW(PAGE_AW), .CFG_AW(CFG_AW),
             .REV_CODE(REV_CODE)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .cfg_i    (is_cfg),
    .page_i   (ptr[AW-1:PAGE_AW]),
    .mask_i   (pmask),
    .buf_i    (pbuf),
    .raddr_i  (ptr),
    .rdata_o  (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      commit_q   <= 1'b0;
    end else begin
      rd_valid_q <= rd_ev_i && !addr_ev_i && !data_ev_i;
      commit_q   <= commit;
      if (rd_ev_i && !addr_ev_i && !data_ev_i) rd_data_q <= rdata;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign ptr_o      = ptr;
  assign commit_o   = commit_q;
endmodule

// File: rtl/ee_word_ctl_chk.sv
module ee_word_ctl_chk #(
  parameter int unsigned   DW       = 8,
  parameter int unsigned   BANK_AW  = 8,
  parameter int unsigned   PAGE_AW  = 4,
  parameter int unsigned   CFG_AW   = 4,
  parameter logic [DW-1:0] REV_CODE = 8'h3C
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       space_i,
  input logic             addr_ev_i,
  input logic             data_ev_i,
  input logic             rd_ev_i,
  input logic             stop_ev_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             rd_valid_o,
  input logic [BANK_AW:0] ptr_o,
  input logic             commit_o
);
  // R2: in-page increment, upper bits held
  p_page_low_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ev_i && !addr_ev_i) |=>
      (ptr_o[PAGE_AW-1:0] == $past(ptr_o[PAGE_AW-1:0]) + PAGE_AW'(1)) &&
      (ptr_o[BANK_AW:PAGE_AW] == $past(ptr_o[BANK_AW:PAGE_AW])));

  // R3: commit only as the answer to a stop
  p_commit_after_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_ev_i));

  // R5: read request gives valid data next cycle
  p_read_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && !addr_ev_i && !data_ev_i) |=> rd_valid_o);

  // R6: bank wrap keeps bank select
  p_bank_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && !addr_ev_i && !data_ev_i && space_i == 2'd0 && ptr_o[BANK_AW-1:0] == '1) |=>
      (ptr_o[BANK_AW-1:0] == '0) && (ptr_o[BANK_AW] == $past(ptr_o[BANK_AW])));

  // R7: combined space crosses banks
  p_comb_cross_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && !addr_ev_i && !data_ev_i && space_i == 2'd1) |=>
      ptr_o == $past(ptr_o) + (BANK_AW+1)'(1));

  // R9: revision location reads fixed code
  p_rev_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev_i && !addr_ev_i && !data_ev_i && space_i == 2'd2 && ptr_o[CFG_AW-1:0] == '1) |=>
      rd_data_o == REV_CODE);
endmodule

bind ee_word_ctl ee_word_ctl_chk #(
  .DW(DW), .BANK_AW(BANK_AW), .PAGE_AW(PAGE_AW), .CFG_AW(CFG_AW), .REV_CODE(REV_CODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .space_i    (space_i),
  .addr_ev_i  (addr_ev_i),
  .data_ev_i  (data_ev_i),
  .rd_ev_i    (rd_ev_i),
  .stop_ev_i  (stop_ev_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .ptr_o      (ptr_o),
  .commit_o   (commit_o)
);

// File: tb/ee_word_ctl_bench.sv
module ee_word_ctl_bench;
  localparam logic [7:0] REV = 8'h3C;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] space_i = '0;
  logic       addr_ev_i = 1'b0, addr_hi_i = 1'b0, data_ev_i = 1'b0;
  logic       rd_ev_i = 1'b0, stop_ev_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o, commit_o;
  logic [8:0] ptr_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_mem [512];
  logic [7:0] m_cfg [16];
  logic [7:0] m_buf [16];
  logic [15:0] m_mask;
  logic [8:0] m_ptr;
  logic [1:0] m_sp;

  always #10 clk_i = ~clk_i;

  ee_word_ctl u_ee_word_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .space_i(space_i), .addr_ev_i(addr_ev_i),
    .addr_hi_i(addr_hi_i), .data_ev_i(data_ev_i), .rd_ev_i(rd_ev_i),
    .stop_ev_i(stop_ev_i), .byte_i(byte_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .ptr_o(ptr_o), .commit_o(commit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] rd_next(input logic [1:0] sp, input logic [8:0] p);
    case (sp)
      2'd1:    return p + 9'd1;
      2'd2:    return {p[8:4], p[3:0] + 4'd1};
      default: return {p[8], p[7:0] + 8'd1};
    endcase
  endfunction

  function automatic logic [7:0] rd_model(input logic [1:0] sp, input logic [8:0] p);
    if (sp == 2'd2) return (p[3:0] == 4'hF) ? REV : m_cfg[p[3:0]];
    return m_mem[p];
  endfunction

  task automatic ev_addr(input logic [1:0] sp, input logic hi, input logic [7:0] b, input string req);
    @(negedge clk_i);
    space_i = sp; addr_hi_i = hi; byte_i = b; addr_ev_i = 1'b1;
    @(negedge clk_i);
    addr_ev_i = 1'b0;
    m_sp = sp; m_mask = '0;
    m_ptr = (sp == 2'd2) ? {5'd0, b[3:0]} : {hi, b};
    chk(ptr_o == m_ptr, req, ptr_o, m_ptr);
  endtask

  task automatic ev_data(input logic [7:0] b, input string req);
    @(negedge clk_i);
    byte_i = b; data_ev_i = 1'b1;
    @(negedge clk_i);
    data_ev_i = 1'b0;
    m_buf[m_ptr[3:0]] = b; m_mask[m_ptr[3:0]] = 1'b1;
    m_ptr = {m_ptr[8:4], m_ptr[3:0] + 4'd1};
    chk(ptr_o == m_ptr, req, ptr_o, m_ptr);
  endtask

  task automatic ev_read(input string req);
    logic [7:0] e;
    e = rd_model(m_sp, m_ptr);
    @(negedge clk_i);
    rd_ev_i = 1'b1;
    @(negedge clk_i);
    rd_ev_i = 1'b0;
    m_ptr = rd_next(m_sp, m_ptr);
    chk(rd_valid_o && rd_data_o == e, req, rd_data_o, e);
    chk(ptr_o == m_ptr, req, ptr_o, m_ptr);
  endtask

  task automatic ev_stop(input string req);
    logic ec;
    ec = |m_mask;
    @(negedge clk_i);
    stop_ev_i = 1'b1;
    @(negedge clk_i);
    stop_ev_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (m_mask[i]) begin
        if (m_sp == 2'd2) begin
          if (i != 15) m_cfg[i] = m_buf[i];
        end else m_mem[{m_ptr[8:4], 4'(i)}] = m_buf[i];
      end
    end
    m_mask = '0;
    chk(commit_o == ec, req, commit_o, ec);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = '0;
    for (int i = 0; i < 16; i++) begin m_cfg[i] = '0; m_buf[i] = '0; end
    m_mask = '0; m_ptr = '0; m_sp = 2'd0;
    #45 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ptr_o == 9'd0, "R11 ptr", ptr_o, 0);
    chk(!rd_valid_o && !commit_o, "R11 flags", {rd_valid_o, commit_o}, 0);
    ev_read("R11 mem zero");

    // page write wrapping, last write wins
    ev_addr(2'd0, 1'b0, 8'h3E, "R1 load");
    for (int i = 0; i < 20; i++) ev_data(8'h80 + 8'(i), "R2 R4 page");
    ev_stop("R3 commit");
    ev_addr(2'd1, 1'b0, 8'h2F, "R1 comb load");
    for (int i = 0; i < 18; i++) ev_read("R3 R4 readback");
    ev_stop("R10 no commit");

    // byte write at page end
    ev_addr(2'd0, 1'b1, 8'h5F, "R1 hi");
    ev_data(8'hC3, "R2 offset F wrap");
    chk(ptr_o == 9'h150, "R2 same page", ptr_o, 9'h150);
    ev_stop("R3 byte");

    // partial page keeps untouched bytes
    ev_addr(2'd0, 1'b0, 8'h33, "R1");
    ev_data(8'h11, "R2"); ev_data(8'h22, "R2");
    ev_stop("R3 partial");
    ev_addr(2'd0, 1'b0, 8'h30, "R10 random");
    for (int i = 0; i < 16; i++) ev_read("R3 untouched");
    ev_stop("R10 stop");

    // bank wrap
    ev_addr(2'd0, 1'b1, 8'hFF, "R1");
    ev_read("R6"); ev_read("R6 wrap");
    chk(ptr_o == 9'h101, "R6 bank held", ptr_o, 9'h101);
    ev_stop("R10");

    // combined crossing
    ev_addr(2'd1, 1'b0, 8'hFF, "R1");
    ev_read("R7"); chk(ptr_o == 9'h100, "R7 cross", ptr_o, 9'h100);
    ev_addr(2'd1, 1'b1, 8'hFF, "R1");
    ev_read("R7"); chk(ptr_o == 9'h000, "R7 roll", ptr_o, 0);
    ev_stop("R10");

    // config area
    ev_addr(2'd2, 1'b1, 8'hFE, "R1 R8 cfg load");
    ev_data(8'h5A, "R8"); ev_data(8'hEE, "R9 write F"); ev_data(8'h77, "R8");
    ev_stop("R3 cfg");
    ev_addr(2'd2, 1'b0, 8'h0E, "R8");
    ev_read("R8 cfg E"); ev_read("R9 rev"); ev_read("R8 wrap");
    ev_stop("R10");
    ev_addr(2'd0, 1'b0, 8'h0E, "R8 separate");
    ev_read("R8 main untouched");
    ev_stop("R10");

    // random
    void'($urandom(32'd1234));
    for (int t = 0; t < 120; t++) begin
      logic [1:0] sp;
      int n;
      sp = 2'($urandom % 3);
      if (sp != m_sp) ev_addr(sp, 1'($urandom), 8'($urandom), "R1 rnd");
      if ($urandom % 2) begin
        ev_addr(sp, 1'($urandom), 8'($urandom), "R1 rnd");
        n = $urandom % 21;
        for (int k = 0; k < n; k++) ev_data(8'($urandom), "R2 rnd");
        ev_stop("R3 rnd");
      end else begin
        if ($urandom % 2) ev_addr(sp, 1'($urandom), 8'($urandom), "R10 rnd");
        n = 1 + $urandom % 6;
        for (int k = 0; k < n; k++) ev_read("R5 rnd");
        ev_stop("R10 rnd");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule